// File: doc/BRIEF.md
# Dual-Mode Converter Bus Interface Controller

This block is the processor-facing sequencer of an 8-bit two-step converter. It turns chip-select, read and write strobes into a coarse decision phase, a fine decision phase and a result hand-off. It drives an active-low end-of-conversion flag, a tri-state enable for the data bus, and an open-drain ready line that shares a pin with the write strobe. The analog side is not modelled here. The conversion code arrives on a plain input and is captured at the instant the fine phase completes.

A static mode input selects one of two host protocols. In read-paced mode, a single read strobe both starts the conversion and collects the result. The decision phases are then timed internally by cycle counters. In write-paced mode, the write strobe starts the conversion and sets the length of the coarse phase. A separate read strobe then collects the data. Holding select and read low in this mode gives stand-alone operation, in which each write pulse produces a new result on the bus with no other strobe.

After reset, a power-on window keeps chip select masked so that the controller stays quiet. All strobe inputs are taken as synchronous to `clk_i`.

Top module: `cvt_bus_ctrl`

## Requirements
- R1: For POR_CYCLES clock cycles after reset is released, cs_ni is treated as high. During this window int_no stays 1, bus_oe_o stays 0 and strobes start no conversion. Once the window ends, a cs_ni level held low takes effect.
- R2: The mode encoding is mode_i=0 for read-paced and mode_i=1 for write-paced. In write-paced mode, rdy_drive_low_o and rdy_release_o are both 0 because the shared pin is an input. In read-paced mode, wr_ni has no effect.
- R3: In read-paced mode, rdy_drive_low_o=1 and rdy_release_o=0 while chip select is effective and no result is pending. While a result is pending (int_no=0) or chip select is high, the outputs are the other way round.
- R4: In read-paced mode with chip select low, a falling read strobe starts a conversion. Take the clock edge that first samples rd_ni low as edge 0. int_no is still 1 after edge COARSE_CYCLES+FINE_CYCLES and falls at edge COARSE_CYCLES+FINE_CYCLES+1.
- R5: In read-paced mode, a rise of rd_ni or cs_ni ends the hand-off. bus_oe_o drops after the edge that samples the rise, and int_no returns to 1 one edge later.
- R6: In read-paced mode, if rd_ni or cs_ni goes high before the result is ready, the conversion is abandoned and int_no never falls for it.
- R7: In write-paced mode with chip select low, a falling wr_ni starts a conversion. The coarse phase lasts as long as wr_ni stays low, with no upper limit. Take the edge that first samples wr_ni high as edge 0. int_no falls at edge FINE_CYCLES+1.
- R8: bus_oe_o is 1 only while int_no is 0 and both rd_ni and cs_ni are low. If rd_ni goes low before int_no falls, the bus stays in high impedance until int_no falls.
- R9: In write-paced mode, a rise of rd_ni or cs_ni returns int_no to 1.
- R10: In stand-alone write-paced operation (cs_ni and rd_ni held low), a rising wr_ni returns int_no to 1. The next result then appears on the bus by itself when int_no falls again.
- R11: data_o takes the value of result_i sampled on the edge where the fine phase ends, which is the same edge that drives int_no low. data_o holds that value until the next conversion completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = read-paced, 1 = write-paced |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low (write-paced mode only) |
| result_i | input | DATA_W | Conversion code from the converter core |
| int_no | output | 1 | End-of-conversion flag, active low |
| rdy_drive_low_o | output | 1 | Pull the shared ready pin low |
| rdy_release_o | output | 1 | Release the shared ready pin (external pull-up) |
| bus_oe_o | output | 1 | Data bus drive enable |
| data_o | output | DATA_W | Latched conversion result |

## Verification
The bench builds the block with COARSE_CYCLES=3, FINE_CYCLES=4 and POR_CYCLES=20. These short windows make the latency of every conversion countable to the exact edge in both modes. They also let the power-on window be probed directly, by a read strobe issued while chip select is still masked. A write-low time of 8 cycles, longer than the coarse count, shows that write-paced conversions follow the strobe rather than the counter. Stand-alone runs chain two conversions so that the clear on the write strobe's rise and the automatic bus hand-off can both be observed.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_COARSE = 2'd1,
    PH_FINE   = 2'd2
  } phase_e;

  localparam int unsigned PIN_RD = 0;
  localparam int unsigned PIN_WR = 1;
  localparam int unsigned N_STROBES = 2;
endpackage

// File: rtl/cvt_pin_sampler.sv
module cvt_pin_sampler #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pins_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] cur_q, prev_q;

  for (genvar i = 0; i < N; i++) begin : g_pin
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cur_q[i]  <= 1'b1;
        prev_q[i] <= 1'b1;
      end else begin
        cur_q[i]  <= pins_i[i];
        prev_q[i] <= cur_q[i];
      end
    end
    assign lvl_o[i]  = cur_q[i];
    assign rise_o[i] = cur_q[i] & ~prev_q[i];
    assign fall_o[i] = ~cur_q[i] & prev_q[i];
  end
endmodule

// File: rtl/cvt_por_timer.sv
module cvt_por_timer #(
  parameter int unsigned POR_CYCLES = 750
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(POR_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign busy_o = (cnt_q != LAST);

  // once the window has closed it never reopens
  assert_por_once_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !busy_o);
endmodule

// File: rtl/cvt_phase_seq.sv
module cvt_phase_seq import cvt_pkg::*; #(
  parameter int unsigned COARSE_CYCLES = 4,
  parameter int unsigned FINE_CYCLES   = 6
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   flush_i,
  input  logic   start_i,
  input  logic   wr_paced_i,
  input  logic   coarse_end_i,
  input  logic   abort_i,
  output phase_e phase_o,
  output logic   done_o
);
  localparam int unsigned MAXC = (COARSE_CYCLES > FINE_CYCLES) ? COARSE_CYCLES : FINE_CYCLES;
  localparam int unsigned CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] C_LAST = CW'(COARSE_CYCLES - 1);
  localparam logic [CW-1:0] F_LAST = CW'(FINE_CYCLES - 1);

  phase_e        ph_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else if (flush_i || (ph_q != PH_IDLE && abort_i)) begin
      ph_q  <= PH_IDLE;
      cnt_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (start_i) begin
            ph_q  <= PH_COARSE;
            cnt_q <= '0;
          end
        end
        PH_COARSE: begin
          if (wr_paced_i) begin
            if (coarse_end_i) begin
              ph_q  <= PH_FINE;
              cnt_q <= '0;
            end
          end else if (cnt_q == C_LAST) begin
            ph_q  <= PH_FINE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_FINE: begin
          if (cnt_q == F_LAST) begin
            ph_q  <= PH_IDLE;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          ph_q  <= PH_IDLE;
          cnt_q <= '0;
        end
      endcase
    end
  end

  assign phase_o = ph_q;
  assign done_o  = (ph_q == PH_FINE) && (cnt_q == F_LAST) && !flush_i && !abort_i;

  // write-paced coarse phase waits for the strobe, not the counter
  assert_wr_coarse_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_COARSE && wr_paced_i && !coarse_end_i && !flush_i && !abort_i) |=> ph_q == PH_COARSE);

  assert_abort_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != PH_IDLE && abort_i) |=> ph_q == PH_IDLE);
endmodule

// File: rtl/cvt_result_latch.sv
module cvt_result_latch #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              pending_o,
  output logic [DATA_W-1:0] data_o
);
  logic              pend_q;
  logic [DATA_W-1:0] data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      data_q <= '0;
    end else if (flush_i) begin
      pend_q <= 1'b0;
    end else if (set_i) begin
      pend_q <= 1'b1;
      data_q <= result_i;
    end else if (clr_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pending_o = pend_q;
  assign data_o    = data_q;

  assert_latch_capture_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> data_q == $past(result_i));

  assert_data_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i |=> $stable(data_q));
endmodule

// File: rtl/cvt_bus_ctrl.sv
module cvt_bus_ctrl import cvt_pkg::*; #(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned COARSE_CYCLES = 4,
  parameter int unsigned FINE_CYCLES   = 6,
  parameter int unsigned POR_CYCLES    = 750
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] result_i,
  output logic              int_no,
  output logic              rdy_drive_low_o,
  output logic              rdy_release_o,
  output logic              bus_oe_o,
  output logic [DATA_W-1:0] data_o
);
  logic [N_STROBES-1:0] stb_lvl, stb_rise, stb_fall, stb_pins;
  logic mode_q, cs_q, cs_eff, cs_eff_p, cs_eff_rise;
  logic por_busy, start, abort, clr, done, pending;
  phase_e phase;

  assign stb_pins[PIN_RD] = rd_ni;
  assign stb_pins[PIN_WR] = wr_ni;

  cvt_pin_sampler #(.N(N_STROBES)) u_strobes (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pins_i(stb_pins),
    .lvl_o (stb_lvl),
    .rise_o(stb_rise),
    .fall_o(stb_fall)
  );

  cvt_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_o(por_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      cs_q     <= 1'b1;
      cs_eff_p <= 1'b1;
    end else begin
      mode_q   <= mode_i;
      cs_q     <= cs_ni;
      cs_eff_p <= cs_eff;
    end
  end

  // power-on window masks chip select
  assign cs_eff      = cs_q | por_busy;
  assign cs_eff_rise = cs_eff & ~cs_eff_p;

  assign start = ~cs_eff & (mode_q ? stb_fall[PIN_WR] : stb_fall[PIN_RD]);
  assign abort = ~mode_q & (stb_lvl[PIN_RD] | cs_eff);
  assign clr   = stb_rise[PIN_RD] | cs_eff_rise | (mode_q & stb_rise[PIN_WR]);

  cvt_phase_seq #(
    .COARSE_CYCLES(COARSE_CYCLES),
    .FINE_CYCLES  (FINE_CYCLES)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (por_busy),
    .start_i     (start),
    .wr_paced_i  (mode_q),
    .coarse_end_i(stb_lvl[PIN_WR]),
    .abort_i     (abort),
    .phase_o     (phase),
    .done_o      (done)
  );

  cvt_result_latch #(.DATA_W(DATA_W)) u_latch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (por_busy),
    .set_i    (done),
    .clr_i    (clr),
    .result_i (result_i),
    .pending_o(pending),
    .data_o   (data_o)
  );

  assign int_no          = ~pending;
  assign bus_oe_o        = pending & ~stb_lvl[PIN_RD] & ~cs_eff;
  assign rdy_drive_low_o = ~mode_q & ~cs_eff & ~pending;
  assign rdy_release_o   = ~mode_q & (cs_eff | pending);

  assert_por_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_busy |-> (int_no && !bus_oe_o && phase == PH_IDLE));

  assert_rdy_input_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |-> (!rdy_drive_low_o && !rdy_release_o));

  assert_rdy_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q && !int_no) |-> (rdy_release_o && !rdy_drive_low_o));

  assert_oe_needs_int_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> !int_no);

  assert_oe_needs_rd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_oe_o |-> (!stb_lvl[PIN_RD] && !cs_q));
endmodule

// File: tb/cvt_bus_ctrl_test.sv
module cvt_bus_ctrl_test;
  localparam int C = 3;
  localparam int F = 4;
  localparam int P = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, mode, cs_n, rd_n, wr_n;
  logic [7:0] result;
  logic int_n, rdy_lo, rdy_rel, bus_oe;
  logic [7:0] data;

  cvt_bus_ctrl #(.DATA_W(8), .COARSE_CYCLES(C), .FINE_CYCLES(F), .POR_CYCLES(P)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .result_i(result), .int_no(int_n), .rdy_drive_low_o(rdy_lo), .rdy_release_o(rdy_rel),
    .bus_oe_o(bus_oe), .data_o(data)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  logic [7:0] exp_q[$];
  logic [7:0] exp_b;
  logic int_prev = 1'b1;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // scoreboard monitor: every falling INT pops one expected result
  always @(negedge clk) begin
    if (rst_n) begin
      if (int_prev && !int_n) begin
        if (exp_q.size() == 0) chk(0, "R6 unexpected end of conversion", 0, 1);
        else begin
          exp_b = exp_q.pop_front();
          chk(data == exp_b, "R11 latched result", data, exp_b);
        end
      end
      int_prev = int_n;
    end
  end

  task automatic rd_conv(input logic [7:0] d, input bit by_cs);
    @(negedge clk) result = d; cs_n = 0;
    step(2);
    chk(rdy_lo && !rdy_rel, "R3 RDY pulled low when selected", rdy_lo, 1);
    @(negedge clk) rd_n = 0; exp_q.push_back(d);
    step(C + F + 1);
    chk(int_n == 1, "R4 INT high before final edge", int_n, 1);
    step(1);
    chk(int_n == 0, "R4 INT low at C+F+1", int_n, 0);
    chk(bus_oe == 1, "R8 bus driven at end of conversion", bus_oe, 1);
    chk(rdy_rel && !rdy_lo, "R3 RDY released at end", rdy_rel, 1);
    step(1);
    if (by_cs) cs_n = 1; else rd_n = 1;
    step(1);
    chk(bus_oe == 0 && int_n == 0, "R5 bus off first, INT still low", {bus_oe, int_n}, 0);
    step(1);
    chk(int_n == 1, "R5 INT cleared", int_n, 1);
    rd_n = 1; cs_n = 1;
    step(2);
  endtask

  task automatic wr_conv(input logic [7:0] d, input bit early_rd);
    @(negedge clk) result = d; cs_n = 0; wr_n = 0; exp_q.push_back(d);
    if (early_rd) rd_n = 0;
    step(8);
    chk(int_n == 1, "R7 coarse phase follows WR low", int_n, 1);
    wr_n = 1;
    step(F + 1);
    chk(int_n == 1, "R7 INT high before final edge", int_n, 1);
    chk(bus_oe == 0, "R8 bus high-Z before INT", bus_oe, 0);
    step(1);
    chk(int_n == 0, "R7 INT low at F+1", int_n, 0);
    if (early_rd) begin
      chk(bus_oe == 1, "R8 bus driven once INT falls", bus_oe, 1);
      cs_n = 1;
      step(2);
      chk(int_n == 1, "R9 INT cleared by CS rise", int_n, 1);
    end else begin
      chk(bus_oe == 0, "R8 bus off while RD high", bus_oe, 0);
      rd_n = 0;
      step(1);
      chk(bus_oe == 1, "R8 bus driven on read", bus_oe, 1);
      rd_n = 1;
      step(2);
      chk(int_n == 1 && bus_oe == 0, "R9 INT cleared by RD rise", int_n, 1);
    end
    rd_n = 1; cs_n = 1;
    step(2);
  endtask

  initial begin
    rst_n = 0; mode = 0; cs_n = 1; rd_n = 1; wr_n = 1; result = '0;
    step(3);
    chk(int_n == 1 && bus_oe == 0, "R1 reset state", {int_n, bus_oe}, 2);
    rst_n = 1; cs_n = 0; rd_n = 0;
    step(3);
    chk(rdy_rel && !rdy_lo, "R1 CS masked in power-on window", rdy_lo, 0);
    chk(int_n == 1 && bus_oe == 0, "R1 quiet in power-on window", int_n, 1);
    step(P + C + F + 5);
    chk(int_n == 1, "R1 no conversion from masked strobe", int_n, 1);
    chk(rdy_lo == 1, "R1 CS honoured after window", rdy_lo, 1);
    rd_n = 1; cs_n = 1;
    step(2);

    rd_conv(8'hA5, 0);
    rd_conv(8'h3C, 1);
    rd_conv(8'hFF, 0);

    // R6 abort
    @(negedge clk) cs_n = 0; rd_n = 0;
    step(2);
    rd_n = 1;
    step(C + F + 6);
    chk(int_n == 1, "R6 aborted conversion", int_n, 1);
    cs_n = 1;
    step(2);

    // R2 WR ignored in read-paced mode
    @(negedge clk) cs_n = 0;
    wr_n = 0; step(2); wr_n = 1; step(C + F + 4);
    chk(int_n == 1, "R2 WR ignored in read mode", int_n, 1);
    cs_n = 1;
    step(2);

    mode = 1;
    step(2);
    chk(!rdy_lo && !rdy_rel, "R2 ready driver off in write mode", {rdy_lo, rdy_rel}, 0);
    wr_conv(8'h5A, 0);
    wr_conv(8'h81, 1);

    // R10 stand-alone
    @(negedge clk) cs_n = 0; rd_n = 0; result = 8'h17; wr_n = 0; exp_q.push_back(8'h17);
    step(2);
    wr_n = 1;
    step(F + 2);
    chk(int_n == 0 && bus_oe == 1, "R10 result on bus automatically", {int_n, bus_oe}, 1);
    result = 8'hC3; wr_n = 0; exp_q.push_back(8'hC3);
    step(3);
    chk(int_n == 0 && data == 8'h17, "R10 INT holds through WR low", data, 8'h17);
    wr_n = 1;
    step(2);
    chk(int_n == 1 && bus_oe == 0, "R10 INT cleared by WR rise", int_n, 1);
    step(F);
    chk(int_n == 0 && bus_oe == 1, "R10 next result driven", {int_n, bus_oe}, 1);
    chk(data == 8'hC3, "R11 second stand-alone result", data, 8'hC3);
    cs_n = 1; rd_n = 1;
    step(3);
    chk(exp_q.size() == 0, "R11 all results seen", exp_q.size(), 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog expired", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule